// File: doc/BRIEF.md
# Multiplier-Free Gardner Timing Error Detector

This block produces the timing error term for a Gardner-style symbol synchroniser used with BPSK and QPSK signals. Each baseband clock it takes two 3-bit samples from a low-resolution front end:

- an on-time symbol sample, captured on the rising-edge lane;
- a midpoint sample, captured on the falling-edge lane halfway between the previous symbol and the current one. Upstream logic aligns the two lanes.

Samples arrive in offset-binary form. The block turns them into signed values and keeps the previous symbol. It then weights the midpoint sample by the sign of the symbol-to-symbol change. The weighting is done by passing, negating or zeroing the midpoint value, so the error path contains no multiplier.

The result is clamped to a small signed word and registered. It then drives an external DAC and analog loop filter, which are outside this block. An enable input forces the error word to zero while the shared oscillator loop is being used for frequency acquisition. The symbol history keeps tracking during that time, so the detector can resume cleanly.

Top module: `gardner_ted`

## Requirements
- R1: A sample code c on `sym_code` or `mid_code` is offset binary and stands for the signed value c − 2^(SAMP_W−1). With the default SAMP_W = 3, code 0 is −4, code 4 is 0 and code 7 is +3.
- R2: When the current symbol value is greater than the stored previous symbol value and `en` is high, the error equals the midpoint value.
- R3: When the current symbol value is less than the stored previous symbol value and `en` is high, the error equals the negated midpoint value.
- R4: When the current symbol value equals the stored previous symbol value, the error is zero.
- R5: The error saturates to the signed ERR_W-bit range. With ERR_W = 3, a negated midpoint of +4 is delivered as +3. With the default ERR_W = 4, every result from −4 to +4 passes unchanged.
- R6: `err` is registered. The value computed from the inputs captured at one rising edge of `clk` appears on `err` after that edge and holds for one clock.
- R7: While `en` is low at a rising edge, `err` becomes zero. The previous-symbol register still loads the current symbol at that edge.
- R8: While `rst_n` is low, `err` is zero and the previous-symbol register holds value 0 (code 4 at default width).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Baseband symbol clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Error output enable; low forces the error to zero |
| sym_code | input | SAMP_W | On-time symbol sample, offset binary |
| mid_code | input | SAMP_W | Midpoint sample between previous and current symbol, offset binary |
| err | output | ERR_W | Signed two's-complement timing error |

## Verification
Every error result is due exactly one rising edge after the edge that captures its inputs. The bench therefore drives `sym_code`, `mid_code` and `en` on the falling edge. Along with them it queues the expected value, taken from its own model of the previous symbol. The monitor pops one entry a quarter period after each following rising edge, so each comparison lines up with the single register stage. The effect of a disabled cycle on the history is checked through the next enabled result. Saturation is observed on a second instance with a 3-bit error word, fed the same stimulus.

// File: rtl/gted_pkg.sv
package gted_pkg;

   // Selection applied to the midpoint sample
   typedef enum logic [1:0] {
      STEER_ZERO = 2'd0,
      STEER_PASS = 2'd1,
      STEER_NEG  = 2'd2
   } steer_e;

endpackage

// File: rtl/gted_decode.sv
// Offset-binary to two's complement: subtracting half scale flips the MSB.
module gted_decode #(
   parameter int SAMP_W = 3
) (
   input  logic                     [SAMP_W-1:0] code_i,
   output logic signed              [SAMP_W-1:0] val_o
);
   generate
      if (SAMP_W < 2) begin : g_bad_width
         $error("gted_decode: SAMP_W must be at least 2");
      end
   endgenerate

   always_comb begin
      val_o = $signed({~code_i[SAMP_W-1], code_i[SAMP_W-2:0]});
   end
endmodule

// File: rtl/gted_slope.sv
// Classifies the symbol-to-symbol change into pass / negate / zero.
module gted_slope
   import gted_pkg::*;
#(
   parameter int SAMP_W = 3
) (
   input  logic signed [SAMP_W-1:0] cur_i,
   input  logic signed [SAMP_W-1:0] prev_i,
   output steer_e                   steer_o
);
   localparam int DIFF_W = SAMP_W + 1;

   logic signed [DIFF_W-1:0] diff;

   always_comb begin
      diff = DIFF_W'(cur_i) - DIFF_W'(prev_i);
      if (diff == '0) begin
         steer_o = STEER_ZERO;
      end else if (diff[DIFF_W-1]) begin
         steer_o = STEER_NEG;
      end else begin
         steer_o = STEER_PASS;
      end
   end
endmodule

// File: rtl/gted_steer.sv
// Sign-controlled negation of the midpoint sample (replaces the product).
module gted_steer
   import gted_pkg::*;
#(
   parameter int SAMP_W = 3
) (
   input  logic signed [SAMP_W-1:0] mid_i,
   input  steer_e                   steer_i,
   output logic signed [SAMP_W:0]   raw_o
);
   logic signed [SAMP_W:0] mid_ext;

   always_comb begin
      mid_ext = (SAMP_W + 1)'(mid_i);
      unique case (steer_i)
         STEER_PASS: raw_o = mid_ext;
         STEER_NEG:  raw_o = -mid_ext;
         default:    raw_o = '0;
      endcase
   end
endmodule

// File: rtl/gted_sat.sv
// Fits the raw error into ERR_W bits; a plain sign extension when it already fits.
module gted_sat #(
   parameter int IN_W  = 4,
   parameter int ERR_W = 4
) (
   input  logic signed [IN_W-1:0]  raw_i,
   output logic signed [ERR_W-1:0] err_o
);
   generate
      if (ERR_W < 2) begin : g_bad_width
         $error("gted_sat: ERR_W must be at least 2");
      end

      if (ERR_W >= IN_W) begin : g_extend
         always_comb begin
            err_o = ERR_W'(raw_i);
         end
      end else begin : g_clamp
         localparam int HI = (1 << (ERR_W - 1)) - 1;
         localparam int LO = -(1 << (ERR_W - 1));
         int raw_int;
         always_comb begin
            raw_int = int'(raw_i);
            if (raw_int > HI) begin
               err_o = ERR_W'(HI);
            end else if (raw_int < LO) begin
               err_o = ERR_W'(LO);
            end else begin
               err_o = ERR_W'(raw_i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/gardner_ted.sv
module gardner_ted
   import gted_pkg::*;
#(
   parameter int SAMP_W = 3,
   parameter int ERR_W  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic [SAMP_W-1:0]        sym_code,
   input  logic [SAMP_W-1:0]        mid_code,
   output logic signed [ERR_W-1:0]  err
);
   localparam int RAW_W = SAMP_W + 1;

   generate
      if (SAMP_W < 2) begin : g_bad_samp
         $error("gardner_ted: SAMP_W must be at least 2");
      end
      if (ERR_W < 2) begin : g_bad_err
         $error("gardner_ted: ERR_W must be at least 2");
      end
   endgenerate

   logic signed [SAMP_W-1:0] sym_s;
   logic signed [SAMP_W-1:0] mid_s;
   logic signed [SAMP_W-1:0] prev_q;
   steer_e                   steer;
   logic signed [RAW_W-1:0]  raw;
   logic signed [ERR_W-1:0]  err_d;
   logic signed [ERR_W-1:0]  err_q;

   gted_decode #(.SAMP_W(SAMP_W)) u_dec_sym (.code_i(sym_code), .val_o(sym_s));
   gted_decode #(.SAMP_W(SAMP_W)) u_dec_mid (.code_i(mid_code), .val_o(mid_s));

   gted_slope #(.SAMP_W(SAMP_W)) u_slope (
      .cur_i   (sym_s),
      .prev_i  (prev_q),
      .steer_o (steer)
   );

   gted_steer #(.SAMP_W(SAMP_W)) u_steer (
      .mid_i   (mid_s),
      .steer_i (steer),
      .raw_o   (raw)
   );

   gted_sat #(.IN_W(RAW_W), .ERR_W(ERR_W)) u_sat (
      .raw_i (raw),
      .err_o (err_d)
   );

   // Symbol history tracks every clock, enabled or not
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         err_q  <= '0;
      end else begin
         prev_q <= sym_s;
         err_q  <= en ? err_d : '0;
      end
   end

   assign err = err_q;

   // R2: rising symbols with a positive midpoint give a positive error
   p_rise_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (sym_s > prev_q) && (mid_s > 0)) |=> (err > 0));

   // R3: falling symbols with a positive midpoint give a negative error
   p_fall_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (sym_s < prev_q) && (mid_s > 0)) |=> (err < 0));

   // R4: no symbol change, no error
   p_flat_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_s == prev_q) |=> (err == '0));

   // R7: disabled cycles give zero output
   p_off_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (err == '0));

   // R7: history loads the current symbol regardless of enable
   p_hist_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (prev_q == $past(sym_s)));
endmodule

// File: tb/gardner_ted_bench.sv
module gardner_ted_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SAMP_W     = 3;
   localparam int WDOG       = 5000;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                en;
   logic [SAMP_W-1:0]   sym_code;
   logic [SAMP_W-1:0]   mid_code;
   logic signed [3:0]   err4;
   logic signed [2:0]   err3;

   int checks = 0;
   int errors = 0;
   int prev_m = 0;

   typedef struct {
      int    e4;
      int    e3;
      string tag;
   } exp_t;

   exp_t sb_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   gardner_ted #(.SAMP_W(SAMP_W), .ERR_W(4)) u_gardner_ted (
      .clk (clk), .rst_n (rst_n), .en (en),
      .sym_code (sym_code), .mid_code (mid_code), .err (err4)
   );

   gardner_ted #(.SAMP_W(SAMP_W), .ERR_W(3)) u_gardner_ted_sat (
      .clk (clk), .rst_n (rst_n), .en (en),
      .sym_code (sym_code), .mid_code (mid_code), .err (err3)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int clamp(input int v, input int lo, input int hi);
      return (v > hi) ? hi : ((v < lo) ? lo : v);
   endfunction

   // Driver: applies one input set on the falling edge and queues its expected result
   task automatic drive(input int s, input int m, input bit e, input string tag);
      exp_t x;
      int   sv, mv, raw;
      @(negedge clk);
      sym_code = SAMP_W'(s);
      mid_code = SAMP_W'(m);
      en       = e;
      sv  = s - 4;                  // R1 offset binary
      mv  = m - 4;
      raw = (sv > prev_m) ? mv : ((sv < prev_m) ? -mv : 0);
      if (!e) raw = 0;
      prev_m = sv;
      x.e4  = clamp(raw, -8, 7);
      x.e3  = clamp(raw, -4, 3);    // R5 narrow instance
      x.tag = tag;
      sb_q.push_back(x);
   endtask

   // Monitor: result due one rising edge after capture (R6)
   always @(posedge clk) begin
      #(CLK_PERIOD / 4);
      if (sb_q.size() > 0) begin
         exp_t x;
         x = sb_q.pop_front();
         check(int'(err4) == x.e4, {x.tag, " err4"}, int'(err4), x.e4);
         check(int'(err3) == x.e3, {x.tag, " err3"}, int'(err3), x.e3);
      end
   end

   initial begin
      rst_n    = 1'b0;
      en       = 1'b0;
      sym_code = '0;
      mid_code = '0;
      fork
         begin
            repeat (3) @(negedge clk);
            check(err4 == 4'sd0, "R8 reset err4", int'(err4), 0);
            check(err3 == 3'sd0, "R8 reset err3", int'(err3), 0);
            sym_code = 3'd4;
            rst_n = 1'b1;
            @(negedge clk);
            prev_m = 0;
            // R8: history reset to value 0, so code 5 is a rise and code 3 a fall
            drive(5, 6, 1'b1, "R8");
            drive(3, 6, 1'b1, "R8");
            drive(7, 7, 1'b1, "R2");
            drive(0, 7, 1'b1, "R3");
            drive(0, 1, 1'b1, "R4");
            drive(7, 0, 1'b1, "R5");
            drive(0, 0, 1'b1, "R5");
            // R7: disabled cycle zeroes output but still loads history
            drive(7, 6, 1'b0, "R7");
            drive(7, 6, 1'b1, "R7");
            drive(2, 6, 1'b0, "R7");
            drive(3, 6, 1'b1, "R7");
            // R1: sweep every symbol/midpoint code pair
            for (int s = 0; s < 8; s++) begin
               for (int m = 0; m < 8; m++) begin
                  drive(s, m, 1'b1, "R1");
               end
            end
            // R6: pseudo-random stream with enable toggling
            begin
               int lfsr = 32'h1d2c;
               for (int i = 0; i < 300; i++) begin
                  lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
                  drive((lfsr >> 8) & 7, (lfsr >> 12) & 7, ((lfsr >> 16) & 3) != 0, "R6");
               end
            end
            wait (sb_q.size() == 0);
            repeat (2) @(negedge clk);
         end
         begin
            repeat (WDOG) @(posedge clk);
            errors++;
            $display("FAIL R6 watchdog: actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule